// File: doc/BRIEF.md
# Parallel TMS JTAG Target Selector

This block is the front end of a JTAG programmer that reaches several target devices wired side by side rather than in one chain. The test clock, test data in and test data out wires are common to every target; each target gets its own test mode select (TMS) line and its own active-low reset line. A host-side command names one target, a bit count between 1 and 32, and two vectors: the TMS bits and the TDI bits to send. The block generates TCK from the system clock, steers the TMS bits only onto the named target's line, and returns the TDO bits it sampled together with a one-cycle done pulse.

Every TMS line that is not in use is held high. A TAP that sees TMS high for five TCK cycles ends up in Test-Logic-Reset, where it releases TDO. When a command names a target other than the one used last, the block first runs a fixed number of TCK cycles with all TMS lines high. This parks every device, including the one previously selected, before the new target is driven. As a result only the selected device ever drives the shared TDO wire.

TDI and TMS change while TCK is low, on its falling edge, and TDO is sampled on the rising edge. Between commands TCK rests low. The TCK half period is a whole number of system clocks, set by a parameter.

Top module: `jtag_par_sel`

## Requirements
- R1: After reset: `tck` is 0, all `tms` lines are 1, `busy` and `done` are 0, and all `targetRstN` lines are 1.
- R2: TCK timing.
  - While a command runs, each TCK half period lasts `CLK_DIV` system clocks.
  - The first rising TCK edge comes `CLK_DIV` clocks after the clock edge that accepts the command.
  - Whenever `busy` is 0, `tck` is 0.
- R3: At every instant, at most one `tms` line is 0; every line other than that of the selected target stays 1.
- R4: Parking. If a command names a target different from the last accepted one, or is the first command after reset, the block first gives `PARK_TCKS` rising TCK edges with every `tms` line at 1, and only then starts on the command's bits.
- R5: Bit order and timing.
  - At the k-th rising TCK edge of the shift phase (k counted from 0), the selected `tms[target]` line equals `cmdTms[k]` and `tdi` equals `cmdTdi[k]`. The vectors are sent least significant bit first.
  - These lines change only while `tck` is low.
  - There are exactly `cmdCount` shift-phase rising edges.
- R6: Returned data.
  - When `done` is 1, `rdata[k]` holds the `tdo` value sampled at the k-th shift-phase rising edge.
  - Bits of `rdata` at positions `cmdCount` and above read 0.
- R7: Completion.
  - `done` is high for exactly one clock, in the first clock where `busy` is 0 after a command.
  - A command is accepted only while `busy` is 0.
- R8: Commands while busy.
  - `busy` is 1 from the clock after acceptance until the command completes.
  - A `cmdValid` that arrives while `busy` is 1 is ignored. This includes one naming another target: it starts no TCK edges and does not change the selected target.
- R9: Invalid commands are ignored; `busy` stays 0 and no TCK edge occurs. A command is invalid if it has a `cmdCount` of 0 or above `MAX_BITS`, or a `cmdTarget` of `NUM_TARGETS` or more.
- R10: Each `targetRstN[i]` equals the inverse of `targetRstReq[i]`, one clock later, regardless of any command in progress.
- R11: A command that names the same target as the last accepted command skips the parking cycles. Its first rising TCK edge already carries bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, sampled when busy is 0 |
| cmdTarget | input | $clog2(NUM_TARGETS) | Index of the target device |
| cmdCount | input | $clog2(MAX_BITS+1) | Number of bits to shift, 1 to MAX_BITS |
| cmdTms | input | MAX_BITS | TMS bits, bit 0 sent first |
| cmdTdi | input | MAX_BITS | TDI bits, bit 0 sent first |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-clock pulse when a command completes |
| rdata | output | MAX_BITS | Sampled TDO bits, bit 0 first captured |
| tck | output | 1 | Shared test clock |
| tdi | output | 1 | Shared test data out to the targets |
| tdo | input | 1 | Shared test data from the targets |
| tms | output | NUM_TARGETS | Per-target test mode select |
| targetRstReq | input | NUM_TARGETS | Reset request per target, active high |
| targetRstN | output | NUM_TARGETS | Reset line per target, active low |

## Verification
The bench builds the block with six targets, 32-bit vectors, a park length of five and a TCK divider of 3. The odd divider exercises a half-period counter whose limit is not a power of two. A three-bit target index leaves the out-of-range values 6 and 7 available to drive as invalid targets. The full 32-bit width makes both the one-bit and the 32-bit count boundaries reachable. The bench counts every rising TCK edge and the system clock at which it occurs, so that parking length, bit order, edge spacing and the exclusivity of the TMS lines are all checked against the sequence each command should produce.

// File: rtl/jtsel_pkg.sv
package jtsel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PARK  = 2'd1,
    ST_SHIFT = 2'd2
  } seq_state_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic load;     // latch a new command's vectors
    logic capture;  // sample TDO into the current bit slot
    logic advance;  // present the next TMS/TDI bit
    logic parkAll;  // force every TMS line high
  } dp_ctrl_t;

endpackage

// File: rtl/jtsel_ctrl.sv
module jtsel_ctrl
  import jtsel_pkg::*;
#(
  parameter int NUM_TARGETS = 6,
  parameter int MAX_BITS    = 32,
  parameter int CLK_DIV     = 4,
  parameter int PARK_TCKS   = 5,
  localparam int TGT_W  = $clog2(NUM_TARGETS),
  localparam int CNT_W  = $clog2(MAX_BITS + 1),
  localparam int IDX_W  = $clog2(MAX_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [TGT_W-1:0] cmdTarget,
  input  logic [CNT_W-1:0] cmdCount,
  output logic             busy,
  output logic             done,
  output logic             tck,
  output dp_ctrl_t         ctl,
  output logic [IDX_W-1:0] bitIdx,
  output logic [TGT_W-1:0] selIdx
);

  localparam int DIV_W  = $clog2(CLK_DIV);
  localparam int PARK_W = $clog2(PARK_TCKS);

  seq_state_e        state;
  logic [DIV_W-1:0]  divCnt;
  logic              tckQ;
  logic [PARK_W-1:0] parkCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  len;
  logic [TGT_W-1:0]  curTarget;
  logic              selValid;
  logic              doneQ;

  logic countOk, targetOk, accept, needPark, active;
  logic halfDone, riseNow, fallNow, lastBit;

  assign countOk  = (cmdCount != '0) && (cmdCount <= CNT_W'(MAX_BITS));
  assign targetOk = ({1'b0, cmdTarget} < (TGT_W + 1)'(NUM_TARGETS));
  assign accept   = cmdValid && (state == ST_IDLE) && countOk && targetOk;
  assign needPark = !selValid || (cmdTarget != curTarget);
  assign active   = (state != ST_IDLE);
  assign halfDone = (divCnt == DIV_W'(CLK_DIV - 1));
  assign riseNow  = active && halfDone && !tckQ;
  assign fallNow  = active && halfDone && tckQ;
  assign lastBit  = (bitCnt == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      tckQ      <= 1'b0;
      parkCnt   <= '0;
      bitCnt    <= '0;
      len       <= '0;
      curTarget <= '0;
      selValid  <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (state == ST_IDLE) begin
        divCnt <= '0;
        tckQ   <= 1'b0;
        if (accept) begin
          curTarget <= cmdTarget;
          selValid  <= 1'b1;
          len       <= cmdCount;
          bitCnt    <= '0;
          parkCnt   <= '0;
          state     <= needPark ? ST_PARK : ST_SHIFT;
        end
      end else begin
        if (halfDone) begin
          divCnt <= '0;
          tckQ   <= ~tckQ;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
        if (fallNow) begin
          if (state == ST_PARK) begin
            if (parkCnt == PARK_W'(PARK_TCKS - 1)) state <= ST_SHIFT;
            else parkCnt <= parkCnt + PARK_W'(1);
          end else if (lastBit) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assign ctl.load    = accept;
  assign ctl.capture = (state == ST_SHIFT) && riseNow;
  assign ctl.advance = (state == ST_SHIFT) && fallNow && !lastBit;
  assign ctl.parkAll = (state == ST_PARK) || !selValid;

  assign busy   = active;
  assign done   = doneQ;
  assign tck    = tckQ;
  assign bitIdx = bitCnt[IDX_W-1:0];
  assign selIdx = curTarget;

  // R2: clock rests low outside a command
  p_tck_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck);

  // R8: the selected target cannot move while a command runs
  p_target_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curTarget));

  // R7: completion pulse coincides with the return to idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $fell(busy)));

  // R5: bit pointer never passes the requested length
  p_bit_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitCnt < len));

endmodule

// File: rtl/jtsel_dp.sv
module jtsel_dp
  import jtsel_pkg::*;
#(
  parameter int NUM_TARGETS = 6,
  parameter int MAX_BITS    = 32,
  localparam int TGT_W = $clog2(NUM_TARGETS),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dp_ctrl_t               ctl,
  input  logic [IDX_W-1:0]       bitIdx,
  input  logic [TGT_W-1:0]       selIdx,
  input  logic [MAX_BITS-1:0]    cmdTms,
  input  logic [MAX_BITS-1:0]    cmdTdi,
  input  logic                   tdo,
  output logic [NUM_TARGETS-1:0] tms,
  output logic                   tdi,
  output logic [MAX_BITS-1:0]    rdata
);

  logic [MAX_BITS-1:0] tmsSh;
  logic [MAX_BITS-1:0] tdiSh;
  logic [MAX_BITS-1:0] tdoSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmsSh <= '0;
      tdiSh <= '0;
      tdoSh <= '0;
    end else begin
      if (ctl.load) begin
        tmsSh <= cmdTms;
        tdiSh <= cmdTdi;
        tdoSh <= '0;
      end else begin
        if (ctl.advance) begin
          tmsSh <= {1'b0, tmsSh[MAX_BITS-1:1]};
          tdiSh <= {1'b0, tdiSh[MAX_BITS-1:1]};
        end
        if (ctl.capture) tdoSh[bitIdx] <= tdo;
      end
    end
  end

  // one steerable line per target, the rest parked high
  for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_tmsLine
    assign tms[g] = (!ctl.parkAll && (selIdx == TGT_W'(g))) ? tmsSh[0] : 1'b1;
  end

  assign tdi   = tdiSh[0];
  assign rdata = tdoSh;

  // R3: never more than one TMS line pulled low
  p_unselected_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~tms) <= 1);

endmodule

// File: rtl/jtag_par_sel.sv
module jtag_par_sel
  import jtsel_pkg::*;
#(
  parameter int NUM_TARGETS = 6,
  parameter int MAX_BITS    = 32,
  parameter int CLK_DIV     = 4,
  parameter int PARK_TCKS   = 5,
  localparam int TGT_W = $clog2(NUM_TARGETS),
  localparam int CNT_W = $clog2(MAX_BITS + 1),
  localparam int IDX_W = $clog2(MAX_BITS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  input  logic [TGT_W-1:0]       cmdTarget,
  input  logic [CNT_W-1:0]       cmdCount,
  input  logic [MAX_BITS-1:0]    cmdTms,
  input  logic [MAX_BITS-1:0]    cmdTdi,
  output logic                   busy,
  output logic                   done,
  output logic [MAX_BITS-1:0]    rdata,
  output logic                   tck,
  output logic                   tdi,
  input  logic                   tdo,
  output logic [NUM_TARGETS-1:0] tms,
  input  logic [NUM_TARGETS-1:0] targetRstReq,
  output logic [NUM_TARGETS-1:0] targetRstN
);

  dp_ctrl_t         ctl;
  logic [IDX_W-1:0] bitIdx;
  logic [TGT_W-1:0] selIdx;

  jtsel_ctrl #(
    .NUM_TARGETS(NUM_TARGETS), .MAX_BITS(MAX_BITS),
    .CLK_DIV(CLK_DIV), .PARK_TCKS(PARK_TCKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTarget(cmdTarget),
    .cmdCount(cmdCount), .busy(busy), .done(done), .tck(tck),
    .ctl(ctl), .bitIdx(bitIdx), .selIdx(selIdx)
  );

  jtsel_dp #(
    .NUM_TARGETS(NUM_TARGETS), .MAX_BITS(MAX_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bitIdx(bitIdx), .selIdx(selIdx),
    .cmdTms(cmdTms), .cmdTdi(cmdTdi), .tdo(tdo),
    .tms(tms), .tdi(tdi), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) targetRstN <= '1;
    else       targetRstN <= ~targetRstReq;
  end

  // R10: reset line follows its request one clock later
  p_reset_follow_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (targetRstN == ~$past(targetRstReq)));

endmodule

// File: tb/jtag_par_sel_tb.sv
module jtag_par_sel_tb;

  localparam int NT  = 6;
  localparam int MB  = 32;
  localparam int DIV = 3;
  localparam int PK  = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdTarget = '0;
  logic [5:0] cmdCount = '0;
  logic [MB-1:0] cmdTms = '0, cmdTdi = '0;
  logic busy, done, tck, tdi, tdo;
  logic [MB-1:0] rdata;
  logic [NT-1:0] tms, targetRstN;
  logic [NT-1:0] targetRstReq = '0;

  int checks = 0, fails = 0, cyc = 0;
  int riseCount = 0, offset = 0;
  logic [31:0] tdoPat = '0;
  logic [NT-1:0] tmsLog [64];
  logic tdiLog [64];
  int riseCyc [64];

  always #2 clk = ~clk;

  jtag_par_sel #(.NUM_TARGETS(NT), .MAX_BITS(MB), .CLK_DIV(DIV), .PARK_TCKS(PK)) u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTarget(cmdTarget),
    .cmdCount(cmdCount), .cmdTms(cmdTms), .cmdTdi(cmdTdi), .busy(busy),
    .done(done), .rdata(rdata), .tck(tck), .tdi(tdi), .tdo(tdo), .tms(tms),
    .targetRstReq(targetRstReq), .targetRstN(targetRstN)
  );

  always @(posedge clk) cyc = cyc + 1;

  always @(posedge tck) begin
    if (riseCount < 64) begin
      tmsLog[riseCount]  = tms;
      tdiLog[riseCount]  = tdi;
      riseCyc[riseCount] = cyc;
    end
    riseCount = riseCount + 1;
  end

  assign tdo = (riseCount >= offset && riseCount - offset < 32) ? tdoPat[riseCount - offset] : 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runCmd(input int tgt, input int cnt, input logic [31:0] tmsV,
                        input logic [31:0] tdiV, input logic [31:0] tdoV,
                        input bit expPark, input int injectAt);
    logic [31:0] mask;
    int acceptCyc, n, total, badPark, badTms, badTdi, badLow;
    logic [NT-1:0] exp;
    mask = (cnt == 32) ? 32'hFFFF_FFFF : ((32'h1 << cnt) - 32'h1);
    @(negedge clk);
    riseCount = 0; offset = expPark ? PK : 0; tdoPat = tdoV;
    cmdTarget = 3'(tgt); cmdCount = 6'(cnt); cmdTms = tmsV; cmdTdi = tdiV; cmdValid = 1'b1;
    @(posedge clk); #1 acceptCyc = cyc;
    @(negedge clk); cmdValid = 1'b0;
    check(busy == 1'b1, "R8", "busy after accept", 64'(busy), 64'd1);
    n = 0; badLow = 0;
    while (!done && n < 4000) begin
      @(negedge clk); n++;
      if ($countones(~tms) > 1) badLow++;
      if (n == injectAt) begin
        cmdValid = 1'b1; cmdTarget = 3'((tgt + 1) % NT); cmdCount = 6'd3;
      end else cmdValid = 1'b0;
    end
    check(done == 1'b1, "R7", "done seen", 64'(done), 64'd1);
    check(busy == 1'b0, "R7", "busy low with done", 64'(busy), 64'd0);
    check(badLow == 0, "R3", "cycles with two low TMS", 64'(badLow), 64'd0);
    check(rdata == (tdoV & mask), "R6", "rdata", 64'(rdata), 64'(tdoV & mask));
    total = offset + cnt;
    check(riseCount == total, expPark ? "R4" : "R11", "rising TCK count", 64'(riseCount), 64'(total));
    badPark = 0; badTms = 0; badTdi = 0;
    for (int k = 0; k < offset; k++) if (tmsLog[k] != '1) badPark++;
    for (int k = 0; k < cnt; k++) begin
      exp = '1; exp[tgt] = tmsV[k];
      if (tmsLog[offset + k] != exp) badTms++;
      if (tdiLog[offset + k] != tdiV[k]) badTdi++;
    end
    check(badPark == 0, "R4", "park edges with low TMS", 64'(badPark), 64'd0);
    check(badTms == 0, "R5", "TMS bit mismatches", 64'(badTms), 64'd0);
    check(badTdi == 0, "R5", "TDI bit mismatches", 64'(badTdi), 64'd0);
    check(riseCyc[0] - acceptCyc == DIV, "R2", "first rise delay", 64'(riseCyc[0] - acceptCyc), 64'(DIV));
    check(riseCyc[total-1] - riseCyc[0] == 2 * DIV * (total - 1), "R2", "rise spacing",
          64'(riseCyc[total-1] - riseCyc[0]), 64'(2 * DIV * (total - 1)));
    @(negedge clk);
    check(done == 1'b0, "R7", "done one cycle", 64'(done), 64'd0);
    check(tck == 1'b0, "R2", "tck idle low", 64'(tck), 64'd0);
  endtask

  task automatic tryInvalid(input int tgt, input int cnt);
    int sawBusy;
    @(negedge clk);
    riseCount = 0;
    cmdTarget = 3'(tgt); cmdCount = 6'(cnt); cmdValid = 1'b1;
    @(negedge clk); cmdValid = 1'b0;
    sawBusy = 0;
    repeat (20) begin @(negedge clk); if (busy) sawBusy++; end
    check(sawBusy == 0, "R9", "busy on invalid command", 64'(sawBusy), 64'd0);
    check(riseCount == 0, "R9", "TCK edges on invalid command", 64'(riseCount), 64'd0);
  endtask

  task automatic testResetLines(input logic [NT-1:0] req);
    @(negedge clk); targetRstReq = req;
    @(negedge clk);
    check(targetRstN == ~req, "R10", "reset lines", 64'(targetRstN), 64'(~req));
  endtask

  task automatic testResetState();
    check(tck == 1'b0, "R1", "tck at reset", 64'(tck), 64'd0);
    check(tms == '1, "R1", "tms at reset", 64'(tms), 64'h3F);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset", 64'({busy, done}), 64'd0);
    check(targetRstN == '1, "R1", "reset lines at reset", 64'(targetRstN), 64'h3F);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testResetState();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testResetState();
    // R4: first command parks even for target 0
    runCmd(0, 8, 32'h0000_00A5, 32'h0000_003C, 32'h0000_0096, 1'b1, 0);
    // R11: same target, no parking
    runCmd(0, 5, 32'h0000_0013, 32'h0000_000A, 32'h0000_001F, 1'b0, 0);
    // R4: switch to highest index, single bit
    runCmd(5, 1, 32'h0, 32'h1, 32'h1, 1'b1, 0);
    // R5/R6: full 32-bit shift on a new target
    runCmd(2, 32, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 1'b1, 0);
    // R8: switch request injected mid-shift is ignored
    runCmd(2, 20, 32'h000A_5A5A, 32'h0005_A5A5, 32'h000F_0F0F, 1'b0, 25);
    runCmd(2, 4, 32'h9, 32'h6, 32'h5, 1'b0, 0);
    // R9: invalid commands
    tryInvalid(3, 0);
    tryInvalid(3, 33);
    tryInvalid(6, 4);
    tryInvalid(7, 4);
    // R10: reset lines follow requests
    testResetLines(6'b100101);
    testResetLines(6'b011010);
    testResetLines(6'b000000);
    runCmd(4, 12, 32'h0000_0FF0, 32'h0000_0C3C, 32'h0000_0ABC, 1'b1, 0);
    finishRun();
  end

endmodule